// File: doc/BRIEF.md
# Masked Pattern Match Trigger

This block watches a wide sampled data bus and fires when the sample fits a pattern that software has programmed. The pattern is a value and a care-mask, each spread over several 32-bit words. A mode bit picks one of two meanings for the value. In level mode it is compared with the bus itself. In change mode it is compared with the bits that flipped since the previous valid sample.

Each new run of matching samples yields a single registered pulse. Three side outputs derive from that pulse. One asks for a timestamp of the match. One is the gated trigger. One asks for a timestamp of the trigger. Capturing the timestamp and formatting trace data happen elsewhere.

A two-state sequencer tracks the runs. In SEEK no match is in progress. A valid matching sample takes the transition SEEK->HELD and emits the pulse. In HELD a match run is active. A valid non-matching sample takes the transition HELD->SEEK. Cycles without a valid sample leave the state as it is.

Top module: `pattern_trigger`

## Requirements
- R1: After reset every register reads zero, the previous-sample store is zero, the sequencer is in SEEK, and all four outputs are low.
- R2: Register map on a 5-bit word address: 0..7 hold value word k (bus bits 32k+31..32k); 8..15 hold mask word k; 16 is control (bit0 mode: 0 level, 1 change; bit1 match-timestamp enable; bit2 trigger enable; bit3 trigger-timestamp enable; bits 31..4 read 0). Written words read back through the combinational read port. Any other address reads zero, and writes to it change nothing.
- R3: When every mask bit is zero, no sample ever produces a match.
- R4: In level mode a sample matches when every bus bit whose mask bit is 1 equals the corresponding value bit.
- R5: In change mode a sample matches when, on every masked bit, the XOR of the sample with the previous valid sample equals the value bit.
- R6: match_pulse rises in the cycle after the edge that takes a matching valid sample while in SEEK, and lasts one cycle. Further matching samples give no pulse until a valid non-matching sample has been seen. Cycles with sample_valid low produce no pulse and do not change the state.
- R7: match_ts_req equals match_pulse gated by the match-timestamp enable.
- R8: trig_out equals match_pulse gated by the trigger enable.
- R9: trig_ts_req equals trig_out gated by the trigger-timestamp enable.
- R10: The previous-sample store updates on every valid sample in both modes. The first valid sample after reset is compared against zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 5 | Register write word address |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 5 | Register read word address |
| rd_data | output | 32 | Combinational read data |
| sample_valid | input | 1 | Bus sample present this cycle |
| sample_data | input | 256 | Sampled data bus |
| match_pulse | output | 1 | One-cycle pulse at the start of a match run |
| match_ts_req | output | 1 | Timestamp request for the match |
| trig_out | output | 1 | Gated trigger pulse |
| trig_ts_req | output | 1 | Timestamp request for the trigger |

## Verification
Random 256-bit samples almost never satisfy a mask by chance, and in change mode a match depends on the previous valid sample. Both make runs of consecutive matches hard to reach. The stimulus therefore builds many samples from the programmed pattern. In level mode the masked bits are forced to the value. In change mode the value is XORed into the tracked previous sample. Repeats and idle cycles are mixed in, so runs start, continue across gaps and end in both modes.

// File: rtl/ptrig_pkg.sv
package ptrig_pkg;
    typedef struct packed {
        logic trig_ts;
        logic trig_en;
        logic ts_en;
        logic change_mode;
    } ptrig_ctrl_t;

    typedef enum logic {
        ST_SEEK = 1'b0,
        ST_HELD = 1'b1
    } ptrig_state_e;
endpackage

// File: rtl/ptrig_regs.sv
module ptrig_regs
    import ptrig_pkg::*;
#(
    parameter int BUS_W  = 256,
    parameter int WORD_W = 32,
    parameter int ADDR_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [WORD_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [WORD_W-1:0] rd_data,
    output logic [BUS_W-1:0]  pat_value,
    output logic [BUS_W-1:0]  pat_mask,
    output ptrig_ctrl_t       ctrl
);
    localparam int NWORDS = BUS_W / WORD_W;
    localparam int IDX_W  = $clog2(NWORDS);
    localparam int CTRL_W = $bits(ptrig_ctrl_t);
    localparam logic [ADDR_W-1:0] CTRL_A = ADDR_W'(2 * NWORDS);

    logic [WORD_W-1:0] val_q  [NWORDS];
    logic [WORD_W-1:0] mask_q [NWORDS];

    wire [ADDR_W-IDX_W-1:0] wr_grp = wr_addr[ADDR_W-1:IDX_W];
    wire [ADDR_W-IDX_W-1:0] rd_grp = rd_addr[ADDR_W-1:IDX_W];

    for (genvar k = 0; k < NWORDS; k++) begin : g_word
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                val_q[k]  <= '0;
                mask_q[k] <= '0;
            end else if (wr_en && wr_addr[IDX_W-1:0] == IDX_W'(k)) begin
                if (wr_grp == '0)
                    val_q[k] <= wr_data;
                if (wr_grp == (ADDR_W-IDX_W)'(1))
                    mask_q[k] <= wr_data;
            end
        end
        assign pat_value[k*WORD_W +: WORD_W] = val_q[k];
        assign pat_mask[k*WORD_W +: WORD_W]  = mask_q[k];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            ctrl <= '0;
        else if (wr_en && wr_addr == CTRL_A)
            ctrl <= ptrig_ctrl_t'(wr_data[CTRL_W-1:0]);
    end

    always_comb begin
        rd_data = '0;
        if (rd_grp == '0)
            rd_data = val_q[rd_addr[IDX_W-1:0]];
        else if (rd_grp == (ADDR_W-IDX_W)'(1))
            rd_data = mask_q[rd_addr[IDX_W-1:0]];
        else if (rd_addr == CTRL_A)
            rd_data = WORD_W'(ctrl);
    end

    assert_ctrl_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == CTRL_A) |=> (ctrl == ptrig_ctrl_t'($past(wr_data[CTRL_W-1:0]))));
    assert_ctrl_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && wr_addr == CTRL_A) |=> $stable(ctrl));
endmodule

// File: rtl/ptrig_cmp.sv
module ptrig_cmp #(
    parameter int BUS_W = 256
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sample_valid,
    input  logic [BUS_W-1:0] sample_data,
    input  logic [BUS_W-1:0] pat_value,
    input  logic [BUS_W-1:0] pat_mask,
    input  logic             change_mode,
    output logic             hit
);
    logic [BUS_W-1:0] prev_q;
    logic [BUS_W-1:0] subject;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            prev_q <= '0;
        else if (sample_valid)
            prev_q <= sample_data;
    end

    always_comb begin
        subject = change_mode ? (sample_data ^ prev_q) : sample_data;
        hit     = (|pat_mask) && ~|((subject ^ pat_value) & pat_mask);
    end

    assert_prev_track_R10: assert property (@(posedge clk) disable iff (!rst_n)
        sample_valid |=> (prev_q == $past(sample_data)));
    assert_prev_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !sample_valid |=> $stable(prev_q));
endmodule

// File: rtl/ptrig_seq.sv
module ptrig_seq
    import ptrig_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        sample_valid,
    input  logic        hit,
    input  ptrig_ctrl_t ctrl,
    output logic        match_pulse,
    output logic        match_ts_req,
    output logic        trig_out,
    output logic        trig_ts_req
);
    ptrig_state_e state_q, state_d;
    logic         start_run;

    always_comb begin
        state_d   = state_q;
        start_run = 1'b0;
        unique case (state_q)
            ST_SEEK: if (sample_valid && hit) begin
                state_d   = ST_HELD;
                start_run = 1'b1;
            end
            ST_HELD: if (sample_valid && !hit)
                state_d = ST_SEEK;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_SEEK;
        else
            state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            match_pulse  <= 1'b0;
            match_ts_req <= 1'b0;
            trig_out     <= 1'b0;
            trig_ts_req  <= 1'b0;
        end else begin
            match_pulse  <= start_run;
            match_ts_req <= start_run && ctrl.ts_en;
            trig_out     <= start_run && ctrl.trig_en;
            trig_ts_req  <= start_run && ctrl.trig_en && ctrl.trig_ts;
        end
    end

    assert_single_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        match_pulse |-> !$past(match_pulse));
    assert_pulse_needs_sample_R6: assert property (@(posedge clk) disable iff (!rst_n)
        match_pulse |-> ($past(sample_valid) && state_q == ST_HELD));
    assert_ts_gated_R7: assert property (@(posedge clk) disable iff (!rst_n)
        match_ts_req |-> match_pulse);
    assert_trig_gated_R8: assert property (@(posedge clk) disable iff (!rst_n)
        trig_out |-> match_pulse);
    assert_trig_ts_gated_R9: assert property (@(posedge clk) disable iff (!rst_n)
        trig_ts_req |-> trig_out);
endmodule

// File: rtl/pattern_trigger.sv
module pattern_trigger
    import ptrig_pkg::*;
#(
    parameter int BUS_W  = 256,
    parameter int WORD_W = 32,
    localparam int NWORDS = BUS_W / WORD_W,
    localparam int ADDR_W = $clog2(NWORDS) + 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [WORD_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [WORD_W-1:0] rd_data,
    input  logic              sample_valid,
    input  logic [BUS_W-1:0]  sample_data,
    output logic              match_pulse,
    output logic              match_ts_req,
    output logic              trig_out,
    output logic              trig_ts_req
);
    logic [BUS_W-1:0] pat_value;
    logic [BUS_W-1:0] pat_mask;
    ptrig_ctrl_t      ctrl;
    logic             hit;

    ptrig_regs #(.BUS_W(BUS_W), .WORD_W(WORD_W), .ADDR_W(ADDR_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .pat_value(pat_value), .pat_mask(pat_mask),
        .ctrl(ctrl)
    );

    ptrig_cmp #(.BUS_W(BUS_W)) u_cmp (
        .clk(clk), .rst_n(rst_n), .sample_valid(sample_valid), .sample_data(sample_data),
        .pat_value(pat_value), .pat_mask(pat_mask), .change_mode(ctrl.change_mode), .hit(hit)
    );

    ptrig_seq u_seq (
        .clk(clk), .rst_n(rst_n), .sample_valid(sample_valid), .hit(hit), .ctrl(ctrl),
        .match_pulse(match_pulse), .match_ts_req(match_ts_req),
        .trig_out(trig_out), .trig_ts_req(trig_ts_req)
    );

    assert_zero_mask_R3: assert property (@(posedge clk) disable iff (!rst_n)
        match_pulse |-> $past(|pat_mask));
endmodule

// File: tb/pattern_trigger_tb.sv
module pattern_trigger_tb;
    localparam int CLK_PERIOD = 10;
    localparam int BUS_W = 256;
    localparam int WORD_W = 32;
    localparam int NW = BUS_W / WORD_W;

    logic clk = 0, rst_n = 0;
    logic wr_en = 0;
    logic [4:0] wr_addr = 0, rd_addr = 0;
    logic [31:0] wr_data = 0;
    logic [31:0] rd_data;
    logic sample_valid = 0;
    logic [BUS_W-1:0] sample_data = '0;
    logic match_pulse, match_ts_req, trig_out, trig_ts_req;

    int n_chk = 0, n_fail = 0;
    logic [BUS_W-1:0] m_val = '0, m_mask = '0, m_prev = '0;
    logic [3:0] m_ctrl = '0;
    bit m_held = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pattern_trigger u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .sample_valid(sample_valid),
        .sample_data(sample_data), .match_pulse(match_pulse), .match_ts_req(match_ts_req),
        .trig_out(trig_out), .trig_ts_req(trig_ts_req)
    );

    task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s got=%h exp=%h", req, got, exp);
        end
    endtask

    function automatic logic [BUS_W-1:0] rand256();
        logic [BUS_W-1:0] r;
        for (int i = 0; i < NW; i++) r[i*32 +: 32] = $urandom;
        return r;
    endfunction

    function automatic bit model_hit(logic [BUS_W-1:0] d);
        logic [BUS_W-1:0] s;
        s = m_ctrl[0] ? (d ^ m_prev) : d;
        return (m_mask != '0) && (((s ^ m_val) & m_mask) == '0);
    endfunction

    task automatic wr(int a, logic [31:0] d);
        @(negedge clk);
        wr_en = 1; wr_addr = 5'(a); wr_data = d;
        @(negedge clk);
        wr_en = 0;
        if (a < NW) m_val[a*32 +: 32] = d;
        else if (a < 2*NW) m_mask[(a-NW)*32 +: 32] = d;
        else if (a == 2*NW) m_ctrl = d[3:0];
    endtask

    task automatic rd_chk(string req, int a, logic [31:0] exp);
        @(negedge clk);
        rd_addr = 5'(a);
        #1 chk(req, rd_data, exp);
    endtask

    task automatic step(bit v, logic [BUS_W-1:0] d, string req);
        bit h, p;
        @(negedge clk);
        sample_valid = v; sample_data = d;
        h = v && model_hit(d);
        p = h && !m_held;
        @(posedge clk); #1;
        chk({req, " R6 match"}, 32'(match_pulse), 32'(p));
        chk({req, " R7 ts"}, 32'(match_ts_req), 32'(p & m_ctrl[1]));
        chk({req, " R8 trig"}, 32'(trig_out), 32'(p & m_ctrl[2]));
        chk({req, " R9 trigts"}, 32'(trig_ts_req), 32'(p & m_ctrl[2] & m_ctrl[3]));
        if (v) begin
            m_held = h;
            m_prev = d;
        end
        sample_valid = 0;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        #(CLK_PERIOD * 3);
        #1;
        chk("R1 match", 32'(match_pulse), 0);
        chk("R1 trig", 32'(trig_out), 0);
        rst_n = 1;
        for (int a = 0; a < 32; a++) rd_chk("R1 reg", a, 0);

        // R3: zero mask, value zero, data zero -> never a match
        step(1, '0, "R3");
        step(1, '0, "R3");

        // R2: readback, control upper bits, unmapped addresses
        wr(16, 32'hFFFF_FFFF);
        rd_chk("R2 ctrl", 16, 32'h0000_000F);
        wr(3, 32'hDEAD_BEEF); rd_chk("R2 val", 3, 32'hDEAD_BEEF);
        wr(12, 32'h1234_5678); rd_chk("R2 mask", 12, 32'h1234_5678);
        wr(20, 32'hAAAA_5555); rd_chk("R2 unmapped", 20, 0);
        rd_chk("R2 ctrl kept", 16, 32'h0000_000F);
        rd_chk("R2 val kept", 3, 32'hDEAD_BEEF);
        wr(3, 0); wr(12, 0);

        // R4 level mode, all enables
        wr(16, 32'hE);
        wr(0, 32'h0000_005A); wr(8, 32'h0000_00FF);
        step(1, BUS_W'(32'hFFFF_FF5A), "R4 hit");
        step(1, BUS_W'(32'h0000_005A), "R4 run");
        step(0, '0, "R6 idle");
        step(1, BUS_W'(32'h0000_005A), "R6 still run");
        step(1, BUS_W'(32'h0000_005B), "R4 miss");
        step(1, BUS_W'(32'h0000_005A), "R6 new run");
        // R9 off: trigger without its timestamp
        wr(16, 32'h6);
        step(1, '0, "R4 miss");
        step(1, BUS_W'(32'h0000_005A), "R9 off");

        // R5/R10 change mode
        wr(16, 32'hF);
        wr(0, 32'h0000_0003); wr(8, 32'h0000_000F);
        step(1, BUS_W'(32'h10), "R10 base");
        step(1, BUS_W'(32'h13), "R5 toggle hit");
        step(1, BUS_W'(32'h13), "R5 no toggle");
        step(1, BUS_W'(32'h10), "R5 toggle back");

        // random mixed
        for (int i = 0; i < 3000; i++) begin
            logic [BUS_W-1:0] d;
            int r;
            if (i % 60 == 0) begin
                for (int w = 0; w < NW; w++) begin
                    wr(w, $urandom);
                    wr(NW + w, (i % 600 == 0) ? 32'h0 : ($urandom & $urandom & $urandom));
                end
                wr(16, $urandom);
            end
            r = $urandom % 5;
            if (r == 0) d = rand256();
            else if (r == 4) d = m_prev;
            else begin
                d = (m_val & m_mask) | (rand256() & ~m_mask);
                if (m_ctrl[0]) d = d ^ m_prev;
            end
            step(($urandom % 8) != 0, d, "R4/R5 random");
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule